// File: doc/BRIEF.md
# Burst Flash Asynchronous Access Controller

This block connects an on-chip request port to an external flash device with a 16-bit data path. It runs the flash in its asynchronous mode. Each host read or write becomes a fixed sequence on the flash pins. First an address phase marks the address valid for the device to latch. Then a transfer phase drives output enable for a read or write enable for a write, and this phase lasts until the device raises its ready input. Last comes a recovery phase with every strobe released. A 32-bit host read is split inside the block into two 16-bit flash reads, and the host receives one combined word.

All phase lengths are counted in ticks of an internal divider driven by the master clock. The divider runs at the master clock rate, half that rate or a quarter of that rate, as set by a 2-bit clock-select input. The external burst clock pin stays low because only the asynchronous mode is built. The block is disabled after reset and does nothing until its mode input is set to a nonzero value.

The host side is a valid/ready port with no buffering. A request moves only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole time an access is in progress, and it is also low while the block is disabled. The host must hold its request fields steady until that cycle. A read answers with a one-cycle `rsp_valid` pulse, and this pulse cannot be stalled. A write gives no response. The return of `req_ready` marks that the write is complete.

Top module: `flash_async_ctrl`

## Requirements
- R1: After reset `cfg_mode` = 0 disables the block. While disabled and idle, `req_ready` is 0, `fl_bus_en` is 0, `fl_cs_n`, `fl_avd_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0, and a held `req_valid` starts no flash access.
- R2: `cfg_clk_sel` sets the tick period in master clocks: 1 gives 1, 2 gives 2, 3 gives 4, and the reserved value 0 gives 1. With `fl_rdy` held high, a half-word access takes 4 ticks: 1 address tick, 2 transfer ticks and 1 recovery tick. The number of master clock edges from the accepting edge to the edge after which `rsp_valid` is high equals 4 × period for each flash read.
- R3: `fl_clk` is 0 at all times.
- R4: `req_size` 0 is a byte read, 1 a half-word read, and 2 or 3 a word read. A byte read returns flash bits 7:0 when `req_addr[0]` = 0 and bits 15:8 when it is 1. A byte or half-word read reads flash half-word address `req_addr[23:1]`, and its result is zero-extended in `rsp_data`.
- R5: A word read performs two flash reads, first at half-word address {`req_addr[23:2]`,0} and then at that address + 1. It gives exactly one `rsp_valid`, with `rsp_data[15:0]` from the first read and `rsp_data[31:16]` from the second, and takes 8 × period clock edges.
- R6: The address phase drives `fl_avd_n` and `fl_cs_n` low, and `fl_oe_n` or `fl_we_n` falls only after it. A write drives `fl_we_n` low with `fl_dq_oe` = 1, `fl_dq_o` = `req_wdata` and `fl_addr` = `req_addr[23:1]`. It produces no `rsp_valid` and takes 4 × period clock edges before `req_ready` is high again. `fl_oe_n` and `fl_we_n` are never low together.
- R7: The transfer phase ends only at a tick where `fl_rdy` is 1, and never before its 2 minimum ticks. Read data is taken from `fl_dq_i` at that tick, and each tick with `fl_rdy` = 0 lengthens the access by one tick.
- R8: `req_ready` is 1 only when the block is enabled and idle. `rsp_valid` is high for exactly one cycle per read.
- R9: The clock select and the read/write kind are captured when a request is accepted. A change of `cfg_clk_sel` or of `cfg_mode` during an access does not change that access's timing or result.
- R10: `fl_bus_en` is 1 while `cfg_mode` is nonzero or an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Operating mode, 0 = disabled, nonzero = asynchronous access |
| cfg_clk_sel | input | 2 | Tick divider select (0/1 = 1, 2 = 2, 3 = 4) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = 16-bit write, 0 = read |
| req_size | input | 2 | Read size: 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 32 | Read result, zero-extended |
| fl_clk | output | 1 | Burst clock, held low |
| fl_bus_en | output | 1 | Address, data and chip-select drive enable |
| fl_cs_n | output | 1 | Chip select, active low |
| fl_avd_n | output | 1 | Address valid strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_addr | output | 23 | Flash half-word address |
| fl_dq_o | output | 16 | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 16 | Data from the flash |
| fl_rdy | input | 1 | Flash ready |

## Verification
A sequencer left in the wrong phase shows up at once as a strobe pattern that cannot occur, such as output enable without a preceding address strobe, or the two enables low together. It also shows up as `req_ready` rising while chip select is still low. A wrong divider count or a lost tick changes the gap between acceptance and `rsp_valid` or the return of `req_ready`, and this is seen on the first access after the fault. A wrong half index or a wrong captured half-word produces a wrong second address strobe or a wrong `rsp_data` on the same word read.

// File: rtl/flash_async_pkg.sv
package flash_async_pkg;

  // access sequence phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_XFER  = 2'd2,
    PH_RECOV = 2'd3
  } phase_e;

  // host read sizes; bit 1 set means a full word
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // last value of the divider count for a clock-select code
  function automatic logic [1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'd2:    return 2'd1;
      2'd3:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fac_tick_gen.sv
module fac_tick_gen
  import flash_async_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick,
  output logic       bclk
);

  logic [1:0] cnt_q;
  logic [1:0] last;

  assign last = div_last(sel);
  assign tick = run && (cnt_q == last);
  // only the asynchronous mode exists, so the burst clock pin rests low
  assign bclk = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 2'd1;
  end

endmodule

// File: rtl/fac_seq.sv
module fac_seq
  import flash_async_pkg::*;
#(
  parameter int AVD_TICKS  = 1,
  parameter int XFER_TICKS = 2,
  parameter int REC_TICKS  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   two_halves,
  input  logic   tick,
  input  logic   rdy,
  output phase_e phase,
  output logic   half,
  output logic   cap,
  output logic   finish
);

  localparam int MAXT1 = (AVD_TICKS > XFER_TICKS) ? AVD_TICKS : XFER_TICKS;
  localparam int MAXT  = (MAXT1 > REC_TICKS) ? MAXT1 : REC_TICKS;
  localparam int PC_W  = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [PC_W-1:0] AVD_LAST  = PC_W'(AVD_TICKS - 1);
  localparam logic [PC_W-1:0] XFER_LAST = PC_W'(XFER_TICKS - 1);
  localparam logic [PC_W-1:0] REC_LAST  = PC_W'(REC_TICKS - 1);

  phase_e          phase_q, phase_d;
  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic            half_q, half_d;

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    half_d  = half_q;
    cap     = 1'b0;
    finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ADDR;
          pcnt_d  = '0;
          half_d  = 1'b0;
        end
      end
      PH_ADDR: begin
        if (tick) begin
          if (pcnt_q == AVD_LAST) begin
            phase_d = PH_XFER;
            pcnt_d  = '0;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      PH_XFER: begin
        if (tick) begin
          if (pcnt_q >= XFER_LAST && rdy) begin
            cap     = 1'b1;
            phase_d = PH_RECOV;
            pcnt_d  = '0;
          end else if (pcnt_q < XFER_LAST) begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      PH_RECOV: begin
        if (tick) begin
          if (pcnt_q == REC_LAST) begin
            pcnt_d = '0;
            if (two_halves && !half_q) begin
              half_d  = 1'b1;
              phase_d = PH_ADDR;
            end else begin
              phase_d = PH_IDLE;
              finish  = 1'b1;
            end
          end else begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      half_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      half_q  <= half_d;
    end
  end

  assign phase = phase_q;
  assign half  = half_q;

endmodule

// File: rtl/fac_rsp.sv
module fac_rsp
  import flash_async_pkg::*;
#(
  parameter int FL_DW  = 16,
  parameter int LANE_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic               half,
  input  logic               finish,
  input  logic               is_write,
  input  logic [1:0]         size,
  input  logic [LANE_W-1:0]  lane,
  input  logic [FL_DW-1:0]   dq_i,
  output logic               rsp_valid,
  output logic [2*FL_DW-1:0] rsp_data
);

  localparam int HOST_DW = 2 * FL_DW;

  logic [FL_DW-1:0]   lo_q, hi_q;
  logic [7:0]         byte_sel;
  logic [HOST_DW-1:0] shaped;

  assign byte_sel = lo_q[lane*8 +: 8];

  always_comb begin
    if (size == SZ_BYTE)      shaped = HOST_DW'(byte_sel);
    else if (size == SZ_HALF) shaped = HOST_DW'(lo_q);
    else                      shaped = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (cap && !half) lo_q <= dq_i;
      if (cap && half)  hi_q <= dq_i;
      rsp_valid <= finish && !is_write;
      if (finish && !is_write) rsp_data <= shaped;
    end
  end

endmodule

// File: rtl/flash_async_ctrl.sv
module flash_async_ctrl
  import flash_async_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int FL_DW      = 16,
  parameter int AVD_TICKS  = 1,
  parameter int XFER_TICKS = 2,
  parameter int REC_TICKS  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                cfg_mode,
  input  logic [1:0]                cfg_clk_sel,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [1:0]                req_size,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [FL_DW-1:0]          req_wdata,
  output logic                      rsp_valid,
  output logic [2*FL_DW-1:0]        rsp_data,
  output logic                      fl_clk,
  output logic                      fl_bus_en,
  output logic                      fl_cs_n,
  output logic                      fl_avd_n,
  output logic                      fl_oe_n,
  output logic                      fl_we_n,
  output logic [ADDR_W-$clog2(FL_DW/8)-1:0] fl_addr,
  output logic [FL_DW-1:0]          fl_dq_o,
  output logic                      fl_dq_oe,
  input  logic [FL_DW-1:0]          fl_dq_i,
  input  logic                      fl_rdy
);

  localparam int LANE_W = $clog2(FL_DW / 8);
  localparam int FA_W   = ADDR_W - LANE_W;

  logic              enabled, accept;
  logic              wr_q;
  logic [1:0]        size_q, sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FL_DW-1:0]  wdata_q;
  logic              word_q;
  logic              tick, cap, finish, half;
  phase_e            phase;
  logic              seq_idle;

  assign enabled  = (cfg_mode != 2'd0);
  assign seq_idle = (phase == PH_IDLE);
  assign req_ready = enabled && seq_idle;
  assign accept   = req_valid && req_ready;
  assign word_q   = size_q[1] && !wr_q;

  // request fields are frozen at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      size_q  <= '0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      size_q  <= req_size;
      sel_q   <= cfg_clk_sel;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  fac_tick_gen u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!seq_idle),
    .sel  (sel_q),
    .tick (tick),
    .bclk (fl_clk)
  );

  fac_seq #(
    .AVD_TICKS (AVD_TICKS),
    .XFER_TICKS(XFER_TICKS),
    .REC_TICKS (REC_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .two_halves(word_q),
    .tick      (tick),
    .rdy       (fl_rdy),
    .phase     (phase),
    .half      (half),
    .cap       (cap),
    .finish    (finish)
  );

  fac_rsp #(
    .FL_DW (FL_DW),
    .LANE_W(LANE_W)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .half     (half),
    .finish   (finish),
    .is_write (wr_q),
    .size     (size_q),
    .lane     (addr_q[LANE_W-1:0]),
    .dq_i     (fl_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  // flash address: word reads use a pair-aligned base plus the half index
  always_comb begin
    if (word_q) fl_addr = {addr_q[ADDR_W-1:LANE_W+1], half};
    else        fl_addr = addr_q[ADDR_W-1:LANE_W];
  end

  assign fl_bus_en = enabled || !seq_idle;
  assign fl_cs_n   = !(phase == PH_ADDR || phase == PH_XFER);
  assign fl_avd_n  = !(phase == PH_ADDR);
  assign fl_oe_n   = !(phase == PH_XFER && !wr_q);
  assign fl_we_n   = !(phase == PH_XFER && wr_q);
  assign fl_dq_oe  = wr_q && (phase == PH_XFER || phase == PH_RECOV);
  assign fl_dq_o   = wdata_q;

endmodule

// File: rtl/flash_async_ctrl_chk.sv
module flash_async_ctrl_chk
  import flash_async_pkg::*;
#(
  parameter int FA_W = 23
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_mode,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            fl_cs_n,
  input logic            fl_avd_n,
  input logic            fl_oe_n,
  input logic            fl_we_n,
  input logic [FA_W-1:0] fl_addr,
  input logic            fl_rdy,
  input phase_e          phase
);

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0 && phase == PH_IDLE) |=> fl_cs_n);

  assert_enable_after_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_oe_n) || $fell(fl_we_n)) |-> $past(!fl_avd_n));

  assert_enables_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n));

  assert_xfer_ends_on_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_oe_n) || $rose(fl_we_n)) |-> $past(fl_rdy));

  assert_second_half_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_avd_n) && $past(phase == PH_RECOV)) |-> (fl_addr == $past(fl_addr) + 1'b1));

  assert_rsp_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_ready_while_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> !req_ready);

endmodule

bind flash_async_ctrl flash_async_ctrl_chk #(.FA_W(FA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_mode (cfg_mode),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .fl_cs_n  (fl_cs_n),
  .fl_avd_n (fl_avd_n),
  .fl_oe_n  (fl_oe_n),
  .fl_we_n  (fl_we_n),
  .fl_addr  (fl_addr),
  .fl_rdy   (fl_rdy),
  .phase    (phase)
);

// File: tb/flash_async_ctrl_tb.sv
`timescale 1ns/1ps
module flash_async_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_clk_sel = 2'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        fl_clk, fl_bus_en, fl_cs_n, fl_avd_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [22:0] fl_addr;
  logic [15:0] fl_dq_o, fl_dq_i;
  logic        fl_rdy = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_clk(fl_clk),
    .fl_bus_en(fl_bus_en), .fl_cs_n(fl_cs_n), .fl_avd_n(fl_avd_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_rdy(fl_rdy)
  );

  // flash content model
  function automatic logic [15:0] fdata(input logic [22:0] h);
    logic [31:0] p;
    p = {9'd0, h} * 32'd40503;
    return p[15:0] ^ p[31:16] ^ 16'h5AC3;
  endfunction

  function automatic int period(input logic [1:0] sel);
    case (sel)
      2'd2:    return 2;
      2'd3:    return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [23:0] a);
    logic [15:0] w;
    logic [22:0] base;
    w = fdata(a[23:1]);
    base = {a[23:2], 1'b0};
    if (sz == 2'd0)      return {24'd0, a[0] ? w[15:8] : w[7:0]};
    else if (sz == 2'd1) return {16'd0, w};
    else                 return {fdata(base + 23'd1), fdata(base)};
  endfunction

  assign fl_dq_i = fl_oe_n ? 16'h0000 : fdata(fl_addr);

  // ready stall model and pin monitors
  int          stall_cfg = 0;
  int          stall_left = 0;
  logic [22:0] avd_log [4];
  int          n_avd = 0;
  logic        avd_prev = 1'b1;
  logic [22:0] w_addr;
  logic [15:0] w_data;
  logic        w_oe;
  int          w_seen = 0;
  logic        clk_bad = 1'b0;

  always @(negedge clk) begin
    if (!fl_oe_n || !fl_we_n) begin
      if (stall_left > 0) begin
        fl_rdy = 1'b0;
        stall_left--;
      end else begin
        fl_rdy = 1'b1;
      end
    end else begin
      fl_rdy = (stall_cfg == 0);
      stall_left = stall_cfg;
    end
    if (!fl_avd_n && avd_prev) begin
      if (n_avd < 4) avd_log[n_avd] = fl_addr;
      n_avd++;
    end
    avd_prev = fl_avd_n;
    if (!fl_we_n) begin
      w_addr = fl_addr;
      w_data = fl_dq_o;
      w_oe = fl_dq_oe;
      w_seen++;
    end
    if (fl_clk !== 1'b0) clk_bad = 1'b1;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issues one request, returns latency in clock edges counted from acceptance
  task automatic do_req(input logic wr, input logic [1:0] sz, input logic [23:0] addr,
                        input logic [15:0] wd, input int mid_sel, input int mid_mode,
                        output int lat, output logic [31:0] data, output int nrsp,
                        output logic ready_early, output logic bus_mid, output logic pulse_ok);
    logic fin;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_avd = 0;
    w_seen = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_size = sz;
    req_addr = addr;
    req_wdata = wd;
    @(posedge clk);
    lat = 0;
    nrsp = 0;
    data = '0;
    ready_early = 1'b0;
    bus_mid = 1'b0;
    forever begin
      @(negedge clk);
      if (lat == 0) begin
        req_valid = 1'b0;
        if (mid_sel >= 0) cfg_clk_sel = mid_sel[1:0];
        if (mid_mode >= 0) cfg_mode = mid_mode[1:0];
      end
      lat++;
      if (lat == 2) bus_mid = fl_bus_en;
      if (rsp_valid) begin
        nrsp++;
        data = rsp_data;
      end
      fin = wr ? req_ready : rsp_valid;
      if (lat > 3000) fin = 1'b1;
      if (!fin && req_ready) ready_early = 1'b1;
      if (fin) break;
    end
    lat = lat - 1;
    @(negedge clk);
    pulse_ok = !rsp_valid;
    if (rsp_valid) nrsp++;
  endtask

  int          lat, nrsp;
  logic [31:0] data;
  logic        early, bmid, pok;
  int          cs_low;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(req_ready == 0 && fl_bus_en == 0 && fl_dq_oe == 0, "R1 reset ready/bus_en/dq_oe",
          {29'd0, req_ready, fl_bus_en, fl_dq_oe}, 32'd0);
    check(fl_cs_n && fl_avd_n && fl_oe_n && fl_we_n, "R1 reset strobes",
          {28'd0, fl_cs_n, fl_avd_n, fl_oe_n, fl_we_n}, 32'hF);

    // R1: held request while disabled is ignored
    req_valid = 1'b1;
    req_size = 2'd1;
    cs_low = 0;
    repeat (20) begin
      @(negedge clk);
      if (!fl_cs_n || req_ready) cs_low++;
    end
    req_valid = 1'b0;
    check(cs_low == 0, "R1 no access while disabled", cs_low, 0);

    cfg_mode = 2'd1;
    @(negedge clk);
    check(req_ready == 1 && fl_bus_en == 1, "R10 bus_en/ready when enabled",
          {30'd0, req_ready, fl_bus_en}, 32'h3);

    // R2: latency per clock select, half-word reads
    for (int s = 0; s < 4; s++) begin
      cfg_clk_sel = s[1:0];
      do_req(1'b0, 2'd1, 24'h012346, 16'h0, -1, -1, lat, data, nrsp, early, bmid, pok);
      check(lat == 4 * period(s[1:0]), $sformatf("R2 latency sel=%0d", s), lat, 4 * period(s[1:0]));
      check(data == exp_read(2'd1, 24'h012346), "R4 half data", data, exp_read(2'd1, 24'h012346));
      check(!early, "R8 ready low while busy", {31'd0, early}, 0);
      check(pok && nrsp == 1, "R8 rsp single pulse", nrsp, 1);
    end

    // R4: byte lanes
    cfg_clk_sel = 2'd1;
    do_req(1'b0, 2'd0, 24'h00A510, 16'h0, -1, -1, lat, data, nrsp, early, bmid, pok);
    check(data == exp_read(2'd0, 24'h00A510), "R4 byte lane0", data, exp_read(2'd0, 24'h00A510));
    do_req(1'b0, 2'd0, 24'h00A511, 16'h0, -1, -1, lat, data, nrsp, early, bmid, pok);
    check(data == exp_read(2'd0, 24'h00A511), "R4 byte lane1", data, exp_read(2'd0, 24'h00A511));

    // R5: word read at div 2, from an unaligned address
    cfg_clk_sel = 2'd2;
    do_req(1'b0, 2'd2, 24'h3C0007, 16'h0, -1, -1, lat, data, nrsp, early, bmid, pok);
    check(lat == 16, "R5 word latency", lat, 16);
    check(data == exp_read(2'd2, 24'h3C0007), "R5 word data", data, exp_read(2'd2, 24'h3C0007));
    check(n_avd == 2 && avd_log[0] == 23'h1E0002 && avd_log[1] == 23'h1E0003, "R5 two address strobes",
          {9'd0, avd_log[1]}, 32'h1E0003);
    check(nrsp == 1, "R5 one response", nrsp, 1);
    do_req(1'b0, 2'd3, 24'h000000, 16'h0, -1, -1, lat, data, nrsp, early, bmid, pok);
    check(data == exp_read(2'd3, 24'h000000), "R4 size 3 is word", data, exp_read(2'd3, 24'h000000));

    // R6: write
    cfg_clk_sel = 2'd3;
    do_req(1'b1, 2'd0, 24'h0ABCDE, 16'hBEEF, -1, -1, lat, data, nrsp, early, bmid, pok);
    check(w_seen > 0 && w_addr == 23'h055E6F && w_data == 16'hBEEF && w_oe, "R6 write pins",
          {w_data, 15'd0, w_oe}, {16'hBEEF, 16'd1});
    check(nrsp == 0, "R6 write no response", nrsp, 0);
    check(lat == 16, "R6 write duration", lat, 16);

    // R7: ready stall lengthens the transfer phase
    cfg_clk_sel = 2'd1;
    stall_cfg = 6;
    @(negedge clk);
    do_req(1'b0, 2'd1, 24'h000200, 16'h0, -1, -1, lat, data, nrsp, early, bmid, pok);
    check(lat == 9, "R7 stall latency", lat, 9);
    check(data == exp_read(2'd1, 24'h000200), "R7 stall data", data, exp_read(2'd1, 24'h000200));
    stall_cfg = 0;

    // R9: clock select change mid-access keeps captured rate
    cfg_clk_sel = 2'd3;
    do_req(1'b0, 2'd1, 24'h000404, 16'h0, 1, -1, lat, data, nrsp, early, bmid, pok);
    check(lat == 16, "R9 clk_sel captured", lat, 16);

    // R9/R10: disable mid word access; access completes
    cfg_clk_sel = 2'd1;
    do_req(1'b0, 2'd2, 24'h123458, 16'h0, -1, 0, lat, data, nrsp, early, bmid, pok);
    check(lat == 8 && data == exp_read(2'd2, 24'h123458), "R9 disable mid-access completes",
          data, exp_read(2'd2, 24'h123458));
    check(bmid == 1, "R10 bus_en while busy after disable", {31'd0, bmid}, 1);
    check(req_ready == 0 && fl_bus_en == 0, "R1 disabled after access", {30'd0, req_ready, fl_bus_en}, 0);
    cfg_mode = 2'd2;

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic        wr;
      logic [1:0]  sz;
      logic [23:0] a;
      logic [15:0] wd;
      wr = ($urandom % 4) == 0;
      sz = 2'($urandom % 4);
      a = 24'($urandom);
      wd = 16'($urandom);
      cfg_clk_sel = 2'($urandom % 4);
      stall_cfg = $urandom % 5;
      do_req(wr, sz, a, wd, -1, -1, lat, data, nrsp, early, bmid, pok);
      if (wr) begin
        check(w_addr == a[23:1] && w_data == wd && nrsp == 0, "R6 random write", {w_data, 16'd0}, {wd, 16'd0});
      end else begin
        check(data == exp_read(sz, a) && nrsp == 1, "R4 R5 R7 random read", data, exp_read(sz, a));
      end
      check(!early, "R8 random ready low while busy", {31'd0, early}, 0);
    end
    stall_cfg = 0;

    check(!clk_bad, "R3 burst clock held low", {31'd0, clk_bad}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule